// File: doc/BRIEF.md
# Shift-Register Switching Activity Monitor

This block runs beside a long feedback shift register in a stream cipher. It measures how much the register toggles internally. It keeps a private copy of the register and a running count of the neighbouring bit pairs that differ (a 1 next to a 0, or a 0 next to a 1). From that count it derives a discrete power level. The level goes out as a one-hot select to an external voltage selector, which sets how much current a shunt draws. The block's own data path is digital only. The voltage selector, the shunt and the cipher's feedback logic sit outside it.

When the cipher loads a new state, the block takes the full state vector on a load strobe. It computes the count from scratch with an XOR of each bit with its neighbour followed by a population count, and registers the result in one cycle. After that, each shift updates the count by a signed delta, so the register is never scanned again:

- The entry side adds one when the incoming bit differs from the current first bit.
- The exit side subtracts one when the two last bits differ, because that pair falls off the end.

The count therefore moves by at most one per shift.

The level control is a three-state machine:

- `ST_IDLE`: after reset, no state has been loaded yet. The level is held at maximum.
- `ST_INIT`: entered from any state on a load strobe. It is the cipher's initialisation phase, and the level stays at maximum. It moves to `ST_TRACK` on the `INIT_CYCLES`-th shift after the load.
- `ST_TRACK`: the level follows the count through the threshold bands. A load strobe returns it to `ST_INIT`.

The number of levels (two or three) and the band boundaries are parameters.

Top module: `fsr_activity_monitor`

## Requirements
- R1: While reset is asserted and immediately after it, `activity_o` is 0 and `level_sel_o` has only its top bit set, which marks maximum power.
- R2: A cycle with `load_i` high sets `activity_o`, from the next clock edge on, to the number of indices k in 0..REG_LEN-2 with `load_state_i[k] != load_state_i[k+1]`. A load takes priority over a shift in the same cycle.
- R3: Loading an all-zero or an all-one state gives an activity of 0.
- R4: A shift places `shift_bit_i` at position 0 and moves every bit k to k+1. The count gains one when the new bit differs from the old bit 0.
- R5: In the same shift, the count loses one when the old bits REG_LEN-1 and REG_LEN-2 differ. When both the gain and the loss apply, the count is unchanged.
- R6: With neither load nor shift, the count holds its value.
- R7: From a load until the `INIT_CYCLES`-th following shift, the level select stays at maximum. Once that shift is taken, the state machine is in `ST_TRACK`.
- R8: With three levels in `ST_TRACK`, select bit 0 is set for a count below `THR_LO`, bit 1 for a count from `THR_LO` to `THR_HI` inclusive, and bit 2 for a count above `THR_HI`.
- R9: With two levels in `ST_TRACK`, bit 0 is set for a count below `THR_LO` and bit 1 otherwise.
- R10: `level_sel_o` is registered and always one-hot. At each clock edge it takes the band of the count held before that edge.
- R11: Until the first load after reset, shifts leave the level select at maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Strobe that takes a new register state |
| load_state_i | input | REG_LEN | Full state to load, bit 0 is the entry end |
| shift_i | input | 1 | Shift enable for one register step |
| shift_bit_i | input | 1 | Bit entering position 0 on a shift |
| activity_o | output | $clog2(REG_LEN+1) | Current count of differing neighbour pairs |
| level_sel_o | output | NUM_LEVELS | One-hot power level select, top bit is maximum |

## Verification
The hardest case to reach is a shift where the entering pair and the leaving pair both differ, so the two deltas cancel. In a long register this needs exactly the right bits at both ends, and the count sits still while the contents change. The bench therefore uses an 8-bit register, where every one of the 256 states can be loaded directly. It follows each load with long pseudo-random shift runs that reach every entry/exit combination, including the cancelling one. Two instances, one with three levels and one with two, see the same stimulus. This drives the count across every band boundary in both directions after the initialisation window closes.

// File: rtl/fsr_act_pkg.sv
package fsr_act_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INIT  = 2'd1,
        ST_TRACK = 2'd2
    } mon_state_e;

endpackage

// File: rtl/fsr_act_mirror.sv
module fsr_act_mirror #(
    parameter int REG_LEN = 160
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [REG_LEN-1:0] load_state_i,
    input  logic               shift_i,
    input  logic               shift_bit_i,
    output logic               enter_diff_o,
    output logic               exit_diff_o
);

    logic [REG_LEN-1:0] copy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            copy_q <= '0;
        end else if (load_i) begin
            copy_q <= load_state_i;
        end else if (shift_i) begin
            copy_q <= {copy_q[REG_LEN-2:0], shift_bit_i};
        end
    end

    // Pair created at the entry end, pair discarded at the far end.
    assign enter_diff_o = shift_bit_i ^ copy_q[0];
    assign exit_diff_o  = copy_q[REG_LEN-1] ^ copy_q[REG_LEN-2];

endmodule

// File: rtl/fsr_act_counter.sv
module fsr_act_counter #(
    parameter int REG_LEN = 160,
    parameter int CNT_W   = $clog2(REG_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [REG_LEN-1:0] load_state_i,
    input  logic               shift_i,
    input  logic               enter_diff_i,
    input  logic               exit_diff_i,
    output logic [CNT_W-1:0]   count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REG_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] scan_cnt;

    // Full scan, used only when a new state is loaded.
    always_comb begin
        scan_cnt = '0;
        for (int k = 0; k < REG_LEN - 1; k++) begin
            scan_cnt = scan_cnt + CNT_W'(load_state_i[k] ^ load_state_i[k+1]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= scan_cnt;
        end else if (shift_i) begin
            cnt_q <= cnt_q + CNT_W'(enter_diff_i) - CNT_W'(exit_diff_i);
        end
    end

    assign count_o = cnt_q;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);                                                     // R2

    AST_DELTA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> ((cnt_q == $past(cnt_q)) ||
                                  (cnt_q == $past(cnt_q) + CNT_W'(1)) ||
                                  (cnt_q == $past(cnt_q) - CNT_W'(1))));      // R4

    AST_CANCEL_NET: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i && enter_diff_i && exit_diff_i) |=> $stable(cnt_q)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !load_i) |=> $stable(cnt_q));                             // R6

endmodule

// File: rtl/fsr_act_level_map.sv
module fsr_act_level_map #(
    parameter int REG_LEN    = 160,
    parameter int CNT_W      = $clog2(REG_LEN + 1),
    parameter int NUM_LEVELS = 3,
    parameter int THR_LO     = 81,
    parameter int THR_HI     = 128
) (
    input  logic [CNT_W-1:0]      count_i,
    output logic [NUM_LEVELS-1:0] band_o
);

    localparam logic [CNT_W-1:0] LO_C = CNT_W'(THR_LO);
    localparam logic [CNT_W-1:0] HI_C = CNT_W'(THR_HI);

    initial begin
        if (NUM_LEVELS != 2 && NUM_LEVELS != 3)
            $error("level map supports two or three levels only");
        if (NUM_LEVELS == 3 && THR_HI < THR_LO)
            $error("upper band boundary below lower one");
    end

    generate
        if (NUM_LEVELS == 2) begin : g_two
            always_comb begin
                band_o = (count_i < LO_C) ? 2'b01 : 2'b10;
            end
        end else begin : g_three
            always_comb begin
                if (count_i < LO_C)
                    band_o = 3'b001;
                else if (count_i <= HI_C)
                    band_o = 3'b010;
                else
                    band_o = 3'b100;
            end
        end
    endgenerate

endmodule

// File: rtl/fsr_act_ctrl.sv
module fsr_act_ctrl
    import fsr_act_pkg::*;
#(
    parameter int NUM_LEVELS  = 3,
    parameter int INIT_CYCLES = 160
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic                  shift_i,
    input  logic [NUM_LEVELS-1:0] band_i,
    output logic [NUM_LEVELS-1:0] level_sel_o
);

    localparam int ICW = $clog2(INIT_CYCLES + 1);
    localparam logic [ICW-1:0]        INIT_LAST = ICW'(INIT_CYCLES - 1);
    localparam logic [NUM_LEVELS-1:0] SEL_MAX   = NUM_LEVELS'(1) << (NUM_LEVELS - 1);

    mon_state_e            state_q, state_d;
    logic [ICW-1:0]        init_cnt_q, init_cnt_d;
    logic [NUM_LEVELS-1:0] level_q;

    // Next state and initialisation window counter.
    always_comb begin
        state_d    = state_q;
        init_cnt_d = init_cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_i) begin
                    state_d    = ST_INIT;
                    init_cnt_d = '0;
                end
            end
            ST_INIT: begin
                if (load_i) begin
                    init_cnt_d = '0;
                end else if (shift_i) begin
                    if (init_cnt_q == INIT_LAST) begin
                        state_d = ST_TRACK;
                    end
                    init_cnt_d = init_cnt_q + ICW'(1);
                end
            end
            ST_TRACK: begin
                if (load_i) begin
                    state_d    = ST_INIT;
                    init_cnt_d = '0;
                end
            end
            default: begin
                state_d    = ST_IDLE;
                init_cnt_d = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            init_cnt_q <= '0;
        end else begin
            state_q    <= state_d;
            init_cnt_q <= init_cnt_d;
        end
    end

    // Output register: maximum until tracking, then the band of the count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= SEL_MAX;
        end else begin
            unique case (state_q)
                ST_TRACK: level_q <= band_i;
                ST_IDLE,
                ST_INIT:  level_q <= SEL_MAX;
                default:  level_q <= SEL_MAX;
            endcase
        end
    end

    assign level_sel_o = level_q;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(level_q) == 1);                                             // R10

    AST_LOAD_TO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (state_q == ST_INIT));                                      // R7

    AST_INIT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |=> (level_q == SEL_MAX));                        // R7

    AST_IDLE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (level_q == SEL_MAX));                        // R11

endmodule

// File: rtl/fsr_activity_monitor.sv
module fsr_activity_monitor #(
    parameter int REG_LEN     = 160,
    parameter int NUM_LEVELS  = 3,
    parameter int THR_LO      = 81,
    parameter int THR_HI      = 128,
    parameter int INIT_CYCLES = REG_LEN,
    parameter int CNT_W       = $clog2(REG_LEN + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [REG_LEN-1:0]    load_state_i,
    input  logic                  shift_i,
    input  logic                  shift_bit_i,
    output logic [CNT_W-1:0]      activity_o,
    output logic [NUM_LEVELS-1:0] level_sel_o
);

    logic                  enter_diff;
    logic                  exit_diff;
    logic [CNT_W-1:0]      count;
    logic [NUM_LEVELS-1:0] band;

    fsr_act_mirror #(
        .REG_LEN (REG_LEN)
    ) mirror_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .load_state_i (load_state_i),
        .shift_i      (shift_i),
        .shift_bit_i  (shift_bit_i),
        .enter_diff_o (enter_diff),
        .exit_diff_o  (exit_diff)
    );

    fsr_act_counter #(
        .REG_LEN (REG_LEN),
        .CNT_W   (CNT_W)
    ) counter_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .load_state_i (load_state_i),
        .shift_i      (shift_i),
        .enter_diff_i (enter_diff),
        .exit_diff_i  (exit_diff),
        .count_o      (count)
    );

    fsr_act_level_map #(
        .REG_LEN    (REG_LEN),
        .CNT_W      (CNT_W),
        .NUM_LEVELS (NUM_LEVELS),
        .THR_LO     (THR_LO),
        .THR_HI     (THR_HI)
    ) map_i (
        .count_i (count),
        .band_o  (band)
    );

    fsr_act_ctrl #(
        .NUM_LEVELS  (NUM_LEVELS),
        .INIT_CYCLES (INIT_CYCLES)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .shift_i     (shift_i),
        .band_i      (band),
        .level_sel_o (level_sel_o)
    );

    assign activity_o = count;

endmodule

// File: tb/fsr_activity_monitor_tb_top.sv
module fsr_activity_monitor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int L          = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [L-1:0] load_state = '0;
    logic         shift = 1'b0;
    logic         sbit = 1'b0;
    logic [3:0]   act3, act2;
    logic [2:0]   lvl3;
    logic [1:0]   lvl2;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Bench model: register copy, state (0 idle, 1 init, 2 track), init count, levels.
    logic [L-1:0] m_reg = '0;
    int           m_st  = 0;
    int           m_ic  = 0;
    logic [2:0]   e_lvl3 = 3'b100;
    logic [1:0]   e_lvl2 = 2'b10;
    logic [15:0]  lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsr_activity_monitor #(
        .REG_LEN (L), .NUM_LEVELS (3), .THR_LO (3), .THR_HI (5), .INIT_CYCLES (8)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .load_i (load), .load_state_i (load_state),
        .shift_i (shift), .shift_bit_i (sbit), .activity_o (act3), .level_sel_o (lvl3)
    );

    fsr_activity_monitor #(
        .REG_LEN (L), .NUM_LEVELS (2), .THR_LO (4), .THR_HI (7), .INIT_CYCLES (8)
    ) dut_two_i (
        .clk (clk), .rst_n (rst_n), .load_i (load), .load_state_i (load_state),
        .shift_i (shift), .shift_bit_i (sbit), .activity_o (act2), .level_sel_o (lvl2)
    );

    function automatic int pairs(logic [L-1:0] v);
        int c = 0;
        for (int k = 0; k < L - 1; k++) c += int'(v[k] != v[k+1]);
        return c;
    endfunction

    function automatic logic [2:0] band3(int c);
        if (c < 3) return 3'b001;
        if (c <= 5) return 3'b010;
        return 3'b100;
    endfunction

    function automatic logic [1:0] band2(int c);
        return (c < 4) ? 2'b01 : 2'b10;
    endfunction

    task automatic chk(string tag, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, actual, expected, $time);
        end
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // One cycle: drive at the falling edge, update the model at the rising edge,
    // compare at the next falling edge.
    task automatic step(logic ld, logic [L-1:0] st, logic sh, logic b);
        load = ld; load_state = st; shift = sh; sbit = b;
        @(posedge clk);
        e_lvl3 = (m_st == 2) ? band3(pairs(m_reg)) : 3'b100;
        e_lvl2 = (m_st == 2) ? band2(pairs(m_reg)) : 2'b10;
        if (ld) begin
            m_reg = st; m_st = 1; m_ic = 0;
        end else if (sh) begin
            m_reg = {m_reg[L-2:0], b};
            if (m_st == 1) begin
                if (m_ic == 7) m_st = 2;
                m_ic++;
            end
        end
        @(negedge clk);
        load = 1'b0; shift = 1'b0;
    endtask

    task automatic check_all(string ctag);
        string ltag;
        chk(ctag, int'(act3), pairs(m_reg));
        chk(ctag, int'(act2), pairs(m_reg));
        ltag = (m_st == 0) ? "R11 level" : "R7/R8/R10 level";
        chk(ltag, int'(lvl3), int'(e_lvl3));
        ltag = (m_st == 0) ? "R11 level" : "R7/R9/R10 level";
        chk(ltag, int'(lvl2), int'(e_lvl2));
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        chk("R1 activity", int'(act3), 0);
        chk("R1 level3", int'(lvl3), 3'b100);
        chk("R1 level2", int'(lvl2), 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 activity after release", int'(act2), 0);

        // R11: shifts before any load keep maximum level
        for (int i = 0; i < 20; i++) begin
            step(1'b0, '0, 1'b1, next_bit());
            check_all("R4 R5 pre-load count");
        end

        // R2/R3/R6: every state loaded, with a simultaneous shift that must lose
        for (int s = 0; s < 256; s++) begin
            step(1'b1, L'(s), 1'b1, next_bit());
            if (s == 0 || s == 255) begin
                chk("R3 uniform state", int'(act3), 0);
            end
            check_all("R2 load count");
            step(1'b0, '0, 1'b0, 1'b0);
            check_all("R6 hold count");
        end

        // R4/R5/R7..R10: long shift runs after loads, with idle gaps
        for (int r = 0; r < 24; r++) begin
            logic [L-1:0] seed_state;
            seed_state = lfsr[7:0] ^ L'(r * 37);
            step(1'b1, seed_state, 1'b0, 1'b0);
            check_all("R2 load count");
            for (int i = 0; i < 250; i++) begin
                logic gap;
                gap = next_bit() & next_bit() & next_bit();
                if (gap) begin
                    step(1'b0, '0, 1'b0, 1'b0);
                    check_all("R6 idle count");
                end else begin
                    logic b;
                    b = (r % 3 == 0) ? ~m_reg[0] : ((r % 3 == 1) ? m_reg[0] : next_bit());
                    if (r % 6 == 5) b = next_bit() ^ next_bit();
                    step(1'b0, '0, 1'b1, b);
                    check_all("R4 R5 shift count");
                end
            end
        end

        finished = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule